// File: doc/BRIEF.md
# Quad-Data-Rate Burst-of-Two SRAM

This block is a small on-chip memory with a read-only data port and a write-only data port that share one address bus. Each address holds a pair of words. A read streams both words out on consecutive half-cycles, and a write streams both words in the same way. Both ports can therefore run every half-cycle at the same time, and no bus ever turns around.

The two complementary input clocks are modelled as one base clock `clk` and a phase input `k_ph`. Every rising edge of `clk` is one half-cycle. `k_ph` is high for the edges that stand for the true clock (the K edges) and low for the complementary edges (the K# edges), and it must alternate on every edge. The first edge after reset release is a K edge.

On a K edge the bus carries a read address. On the K# edge that follows, it carries a write address. Byte-lane write masks arrive with each data beat. A read always returns the newest data, including a write accepted at the same K edge whose pair has not reached the array yet.

Top module: `qdr2_sram`

## Requirements
- R1: While reset is asserted and on the first sample after it, `rvalid` is 0 and `rdata` is 0.
- R2: A read is accepted when `rd_n` is low on a K edge. The lower word of the addressed pair appears on `rdata` after the third edge counted from the accepting edge, which is a K# edge. The higher word appears after the fourth edge. `rvalid` is 1 for exactly those two beats.
- R3: The address present on a K edge is the read address. The address present on the K# edge right after a write select is the write address. A read and a write in the same cycle to different addresses do not affect each other.
- R4: Write data sampled on the K edge becomes the lower word, bits [DW-1:0] of the pair. Write data sampled on the following K# edge becomes the higher word.
- R5: `bw_n` bit i, sampled with each beat, masks byte lane i (bits 8i+7..8i) of that beat when it is high. A masked lane keeps its stored value. A lane is written when its bit is low.
- R6: A read accepted on the same K edge as a write to the same address returns the merged pair of that write, lane by lane. This holds even though the write has not reached the array when the read is looked up.
- R7: On half-cycles with no read beat due, `rvalid` is 0 and `rdata` holds its last value.
- R8: Reads accepted on consecutive K edges produce an unbroken stream. `rvalid` stays 1 and the words follow in acceptance order, lower word then higher word for each read.
- R9: When `wr_n` is high on a K edge, the address and data of the following K# edge change no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; every rising edge is one half-cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| k_ph | input | 1 | High when the coming edge is a K edge, low for a K# edge |
| rd_n | input | 1 | Active-low read select, sampled on K edges |
| wr_n | input | 1 | Active-low write select, sampled on K edges |
| addr | input | AW | Shared address: read address on K, write address on K# |
| wdata | input | DW | Write data beat, sampled on both edges |
| bw_n | input | DW/8 | Active-low byte-lane write enables, one bit per 8-bit lane, sampled on both edges |
| rdata | output | DW | Read data beat |
| rvalid | output | 1 | High while `rdata` carries a read beat |

## Verification
The bench numbers every `clk` edge after reset. When a read is accepted on K edge n, it books the lower word for edge n+3 and the higher word for edge n+4. The reference model applies each write in full on its K# edge, so the read's lookup on edge n+2 already sees a write from edge n. After every edge the bench waits a quarter period and then compares `rvalid` and `rdata` with the booking for that edge number. On edges with nothing booked, it checks that `rvalid` is low and `rdata` is unchanged.

// File: rtl/qdr2_pkg.sv
package qdr2_pkg;
  localparam int LANE_W = 8;

  // number of byte lanes covering a word of dw bits
  function automatic int lanes(input int dw);
    return (dw + LANE_W - 1) / LANE_W;
  endfunction
endpackage

// File: rtl/qdr2_lane_merge.sv
module qdr2_lane_merge #(
  parameter int DW = 8,
  parameter int NB = 1
) (
  input  logic [DW-1:0] old_w,
  input  logic [DW-1:0] new_w,
  input  logic [NB-1:0] keep_n,
  output logic [DW-1:0] out_w
);
  localparam int LW = qdr2_pkg::LANE_W;

  // a lane whose keep_n bit is high retains the old byte
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign out_w[i*LW +: LW] = keep_n[i] ? old_w[i*LW +: LW] : new_w[i*LW +: LW];
  end
endmodule

// File: rtl/qdr2_wr_capture.sv
module qdr2_wr_capture #(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int NB = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            k_ph,
  input  logic            wr_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NB-1:0]   bw_n,
  output logic            pend_vld,
  output logic [AW-1:0]   pend_addr,
  output logic [2*DW-1:0] pend_data,
  output logic [2*NB-1:0] pend_bw_n,
  output logic            commit_go
);
  logic          wsel;
  logic [DW-1:0] lo_d;
  logic [NB-1:0] lo_m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wsel     <= 1'b0;
      pend_vld <= 1'b0;
    end else begin
      pend_vld <= 1'b0;
      if (k_ph) begin
        wsel <= !wr_n;
        lo_d <= wdata;
        lo_m <= bw_n;
      end else if (wsel) begin
        pend_vld  <= 1'b1;
        pend_addr <= addr;
        pend_data <= {wdata, lo_d};
        pend_bw_n <= {bw_n, lo_m};
      end
    end
  end

  // the full pair is written into the array on the K edge after capture
  assign commit_go = pend_vld && k_ph;
endmodule

// File: rtl/qdr2_pair_array.sv
module qdr2_pair_array #(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int NB = 1
) (
  input  logic            clk,
  input  logic            commit_go,
  input  logic [AW-1:0]   wa,
  input  logic [2*DW-1:0] wd,
  input  logic [2*NB-1:0] wbw_n,
  input  logic [AW-1:0]   ra,
  output logic [2*DW-1:0] rd_pair
);
  localparam int DEPTH = 1 << AW;

  logic [2*DW-1:0] mem [DEPTH];
  logic [2*DW-1:0] old_pair;
  logic [2*DW-1:0] new_pair;

  assign old_pair = mem[wa];
  assign rd_pair  = mem[ra];

  for (genvar b = 0; b < 2; b++) begin : g_beat
    qdr2_lane_merge #(.DW(DW), .NB(NB)) merge_i (
      .old_w (old_pair[b*DW +: DW]),
      .new_w (wd[b*DW +: DW]),
      .keep_n(wbw_n[b*NB +: NB]),
      .out_w (new_pair[b*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (commit_go) mem[wa] <= new_pair;
  end
endmodule

// File: rtl/qdr2_rd_path.sv
module qdr2_rd_path #(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int NB = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            k_ph,
  input  logic            rd_n,
  input  logic [AW-1:0]   addr,
  input  logic [2*DW-1:0] arr_pair,
  input  logic            pend_vld,
  input  logic [AW-1:0]   pend_addr,
  input  logic [2*DW-1:0] pend_data,
  input  logic [2*NB-1:0] pend_bw_n,
  output logic [AW-1:0]   raddr,
  output logic            stg_vld,
  output logic [DW-1:0]   rdata,
  output logic            rvalid
);
  logic            rsel;
  logic            hit;
  logic [2*NB-1:0] fwd_keep_n;
  logic [2*DW-1:0] lookup;
  logic [2*DW-1:0] stg;

  // a write still waiting for the array overrides the stored lanes it enables
  assign hit        = pend_vld && (pend_addr == raddr);
  assign fwd_keep_n = hit ? pend_bw_n : '1;

  for (genvar b = 0; b < 2; b++) begin : g_fwd
    qdr2_lane_merge #(.DW(DW), .NB(NB)) fwd_i (
      .old_w (arr_pair[b*DW +: DW]),
      .new_w (pend_data[b*DW +: DW]),
      .keep_n(fwd_keep_n[b*NB +: NB]),
      .out_w (lookup[b*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsel    <= 1'b0;
      stg_vld <= 1'b0;
      rdata   <= '0;
      rvalid  <= 1'b0;
    end else begin
      rvalid <= stg_vld;
      if (k_ph) begin
        rsel    <= !rd_n;
        raddr   <= addr;
        stg_vld <= rsel;
        if (rsel) stg <= lookup;
        if (stg_vld) rdata <= stg[2*DW-1:DW];
      end else if (stg_vld) begin
        rdata <= stg[DW-1:0];
      end
    end
  end
endmodule

// File: rtl/qdr2_sram.sv
module qdr2_sram #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          k_ph,
  input  logic                          rd_n,
  input  logic                          wr_n,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  input  logic [qdr2_pkg::lanes(DW)-1:0] bw_n,
  output logic [DW-1:0]                 rdata,
  output logic                          rvalid
);
  localparam int NB = qdr2_pkg::lanes(DW);

  logic            pend_vld;
  logic [AW-1:0]   pend_addr;
  logic [2*DW-1:0] pend_data;
  logic [2*NB-1:0] pend_bw_n;
  logic            commit_go;
  logic [AW-1:0]   raddr;
  logic [2*DW-1:0] arr_pair;
  logic            stg_vld;

  qdr2_wr_capture #(.DW(DW), .AW(AW), .NB(NB)) wr_i (
    .clk(clk), .rst_n(rst_n), .k_ph(k_ph), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .bw_n(bw_n), .pend_vld(pend_vld), .pend_addr(pend_addr),
    .pend_data(pend_data), .pend_bw_n(pend_bw_n), .commit_go(commit_go)
  );

  qdr2_pair_array #(.DW(DW), .AW(AW), .NB(NB)) arr_i (
    .clk(clk), .commit_go(commit_go), .wa(pend_addr), .wd(pend_data),
    .wbw_n(pend_bw_n), .ra(raddr), .rd_pair(arr_pair)
  );

  qdr2_rd_path #(.DW(DW), .AW(AW), .NB(NB)) rd_i (
    .clk(clk), .rst_n(rst_n), .k_ph(k_ph), .rd_n(rd_n), .addr(addr),
    .arr_pair(arr_pair), .pend_vld(pend_vld), .pend_addr(pend_addr),
    .pend_data(pend_data), .pend_bw_n(pend_bw_n), .raddr(raddr),
    .stg_vld(stg_vld), .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: rtl/qdr2_sram_chk.sv
module qdr2_sram_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          k_ph,
  input logic          rvalid,
  input logic [DW-1:0] rdata,
  input logic          pend_vld,
  input logic          stg_vld
);
  // R2
  beat_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |=> rvalid);

  // R2
  first_beat_kn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> !$past(k_ph));

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> rvalid);

  // R3
  wr_addr_kn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld |-> k_ph);

  // R6
  pend_one_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld |=> !pend_vld);

  // R8
  lookup_on_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stg_vld) |-> !k_ph);
endmodule

bind qdr2_sram qdr2_sram_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .k_ph(k_ph), .rvalid(rvalid), .rdata(rdata),
  .pend_vld(pend_vld), .stg_vld(stg_vld)
);

// File: tb/qdr2_sram_tb.sv
module qdr2_sram_tb_top;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int AW = 6;
  localparam int NB = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          k_ph = 1'b1;
  logic          rd_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NB-1:0] bw_n = '1;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  // reference state
  logic [DW-1:0] m_lo [DEPTH];
  logic [DW-1:0] m_hi [DEPTH];
  bit            exp_v [int];
  logic [DW-1:0] exp_d [int];
  int            edge_n = 0;
  bit            r_pend = 0;
  int            r_a = 0;
  bit            w_pend = 0;
  logic [DW-1:0] w_lo;
  logic [NB-1:0] w_lom;
  logic [DW-1:0] last_rd = '0;
  string         cur_req = "R2";

  qdr2_sram #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .k_ph(k_ph), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .bw_n(bw_n), .rdata(rdata), .rvalid(rvalid)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at edge %0d", req, act, exp, edge_n);
    end
  endtask

  function automatic logic [DW-1:0] put_lanes(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] nw,
                                              input logic [NB-1:0] en_n);
    logic [DW-1:0] r = cur;
    for (int i = 0; i < NB; i++)
      if (en_n[i] == 1'b0) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  // one half-cycle: drive, wait for the edge, update model, sample
  task automatic half(input logic rdn, input logic wrn, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input logic [NB-1:0] bwn);
    rd_n = rdn; wr_n = wrn; addr = a; wdata = wd; bw_n = bwn;
    @(posedge clk);
    edge_n++;
    if (k_ph) begin
      if (r_pend) begin
        exp_v[edge_n+1] = 1'b1; exp_d[edge_n+1] = m_lo[r_a];
        exp_v[edge_n+2] = 1'b1; exp_d[edge_n+2] = m_hi[r_a];
      end
      r_pend = !rdn; r_a = int'(a);
      w_pend = !wrn; w_lo = wd; w_lom = bwn;
    end else if (w_pend) begin
      m_lo[a] = put_lanes(m_lo[a], w_lo, w_lom);
      m_hi[a] = put_lanes(m_hi[a], wd, bwn);
      w_pend = 0;
    end
    #(CLK_P/4);
    if (exp_v.exists(edge_n)) begin
      chk("R2 rvalid on beat", 32'(rvalid), 32'd1);
      chk(cur_req, 32'(rdata), 32'(exp_d[edge_n]));
      last_rd = exp_d[edge_n];
    end else begin
      chk("R7 rvalid idle", 32'(rvalid), 32'd0);
      chk("R7 rdata held", 32'(rdata), 32'(last_rd));
    end
    k_ph = ~k_ph;
    @(negedge clk);
  endtask

  // one full cycle: K edge carries read address, K# edge write address
  task automatic cyc(input logic rdn, input logic [AW-1:0] ra,
                     input logic wrn, input logic [AW-1:0] wa,
                     input logic [DW-1:0] d0, input logic [NB-1:0] m0,
                     input logic [DW-1:0] d1, input logic [NB-1:0] m1);
    half(rdn, wrn, ra, d0, m0);
    half(1'b1, 1'b1, wa, d1, m1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, '0, 1'b1, '0, '0, '1, '0, '1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    nerr++;
    $display("FAIL watchdog expired before the run ended");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 rvalid in reset", 32'(rvalid), 32'd0);
    chk("R1 rdata in reset", 32'(rdata), 32'd0);
    rst_n = 1'b1;
    k_ph = 1'b1;

    // fill every pair; lower beat on K, higher on K#
    cur_req = "R4 pair order";
    for (int a = 0; a < DEPTH; a++)
      cyc(1'b1, '0, 1'b0, AW'(a), DW'(a * 3 + 1), '0, DW'(~a), '0);
    idle(2);

    cur_req = "R2 single read";
    cyc(1'b0, 6'd5, 1'b1, '0, '0, '1, '0, '1);
    idle(3);

    cur_req = "R8 read stream";
    for (int a = 10; a < 20; a++) cyc(1'b0, AW'(a), 1'b1, '0, '0, '1, '0, '1);
    idle(3);

    cur_req = "R5 lane mask";
    cyc(1'b1, '0, 1'b0, 6'd7, 8'hA5, 1'b1, 8'h3C, 1'b0);
    cyc(1'b1, '0, 1'b0, 6'd8, 8'h5A, 1'b0, 8'hC3, 1'b1);
    idle(1);
    cyc(1'b0, 6'd7, 1'b1, '0, '0, '1, '0, '1);
    cyc(1'b0, 6'd8, 1'b1, '0, '0, '1, '0, '1);
    idle(3);

    cur_req = "R9 no write select";
    cyc(1'b1, '0, 1'b1, 6'd9, 8'hEE, 1'b0, 8'hDD, 1'b0);
    idle(1);
    cyc(1'b0, 6'd9, 1'b1, '0, '0, '1, '0, '1);
    idle(3);

    cur_req = "R3 shared bus";
    cyc(1'b0, 6'd20, 1'b0, 6'd21, 8'h11, 1'b0, 8'h22, 1'b0);
    cyc(1'b0, 6'd21, 1'b1, '0, '0, '1, '0, '1);
    idle(3);

    cur_req = "R6 same edge forward";
    cyc(1'b0, 6'd30, 1'b0, 6'd30, 8'h77, 1'b0, 8'h88, 1'b0);
    cyc(1'b0, 6'd31, 1'b0, 6'd31, 8'h99, 1'b1, 8'h66, 1'b0);
    cyc(1'b0, 6'd31, 1'b0, 6'd31, 8'h44, 1'b0, 8'h55, 1'b1);
    idle(3);

    cur_req = "R6 R8 mixed traffic";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r = $urandom;
      logic [31:0] d = $urandom;
      cyc(r[0], AW'(r[11:8] & 4'h7), r[1], AW'(r[15:12] & 4'h7),
          d[7:0], NB'(r[2] & r[3]), d[15:8], NB'(r[4] & r[5]));
    end
    idle(3);

    finish_run();
  end
endmodule